// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the target (slave) side of an I2C link that lets a bus host read and write a small bank of 8-bit registers. Both bus lines arrive as raw samples taken by the system clock. Each line passes through a two-flop synchroniser and then a counter-based deglitcher before any edge is decoded. START, repeated START and STOP are seen as SDA edges while the filtered SCL is high. Every other SCL edge is a data or acknowledge clock.

After a START the first byte must carry the fixed prefix 1010, then the three strap bits, then the read/write flag. A write sends a register address byte and then one or more data bytes. Each data byte is committed on its ninth clock, and the pointer then moves to the next register. A read first sets the pointer with a write-addressed transfer, then issues a repeated START and an identification byte with the read flag set. The target then streams registers until the host refuses a byte. SDA is never driven high: the block only pulls it low, through an open-drain enable.

The registers reset to a common preset value. Their contents are presented in parallel to the surrounding logic.

Top module: `i2ct_target`

## Requirements
- R1: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks is rejected and has no effect on the transfer in progress. A level must hold for FILT_CYCLES clocks after synchronisation before it is accepted.
- R2: The first byte after START is accepted only when bits 7..4 equal 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 is the direction flag: 1 means read, 0 means write. On a match the target pulls SDA low in the ninth clock. On a mismatch SDA stays released and all further bytes are ignored until the next START or STOP.
- R3: In a write, the byte after the identification byte is acknowledged and loads the register pointer.
- R4: Each write data byte is acknowledged, and its value reaches the addressed register at the ninth clock of that byte.
- R5: Further data bytes in the same write land in consecutive registers, because the pointer increments after every data byte.
- R6: A read (repeated START plus an identification byte with bit 0 = 1) returns the register at the pointer. Bits are sent MSB first, and SDA changes only after SCL falling edges.
- R7: When the host acknowledges a read byte (SDA low in the ninth clock), the next register follows. A host NACK (SDA high) leaves SDA released until the next START or STOP.
- R8: Reading an address at or above NUM_REGS returns 00h. Writing such an address is acknowledged and changes no register.
- R9: After reset every register holds RESET_VALUE (40h by default) and SDA is released.
- R10: After a STOP the target is idle: it ignores clocked bytes until a new START.
- R11: An SDA change accepted in the same filtered cycle as an SCL rising edge is sampled as a data bit. It is never taken for START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| strap_i | input | 3 | Strapped low bits of the target identifier |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | 8*NUM_REGS | Register contents, register i in bits 8*i+7..8*i |

## Verification
Two bus functions share one decision point in this block: a filtered SCL rising edge and a filtered SDA transition can be accepted in the same system-clock cycle. A START or STOP decoder that looked only at the current SCL level would then take a data bit for a bus condition. The bench provokes this by writing a data byte whose SDA changes are applied on the very cycle SCL is raised, so that both lines pass the equal-length filters together. The byte contains both rising and falling SDA steps. The bench judges the case by the value that reaches the register (expected A5h) and by the acknowledge, which would be lost if a false START or STOP had been taken. Short glitches on both lines, placed where an accepted glitch would form an extra clock or a false START, are judged the same way.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] ID_PREFIX = 4'b1010;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ID,
        PH_ADDR,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic  we;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    function automatic logic id_match(input byte_t b, input logic [2:0] strap);
        return b[7:1] == {ID_PREFIX, strap};
    endfunction
endpackage

// File: rtl/i2ct_filter.sv
`timescale 1ns/1ps
module i2ct_filter #(
    parameter int FILT_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

    logic          sync1, sync2, level_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            level_q <= 1'b1;
            cnt     <= '0;
        end else begin
            sync1 <= raw_i;
            sync2 <= sync1;
            if (sync2 == level_q) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                level_q <= sync2;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign filt_o = level_q;

    // R1: an accepted level was already present in the synchroniser one and two cycles earlier
    assert_filter_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> ($past(sync2) == level_q) && ($past(sync1, 2) == level_q));
endmodule

// File: rtl/i2ct_regbank.sv
`timescale 1ns/1ps
module i2ct_regbank
    import i2ct_pkg::*;
#(
    parameter int    NUM_REGS    = 2,
    parameter byte_t RESET_VALUE = 8'h40
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 req,
    input  byte_t                   rd_addr,
    output byte_t                   rd_data,
    output logic [NUM_REGS*8-1:0]   regs_o
);
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    byte_t regs [NUM_REGS];
    logic  wr_hit, rd_hit;

    assign wr_hit = req.we && (int'(req.addr) < NUM_REGS);
    assign rd_hit = int'(rd_addr) < NUM_REGS;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= RESET_VALUE;
        end else if (wr_hit) begin
            regs[req.addr[AW-1:0]] <= req.data;
        end
    end

    assign rd_data = rd_hit ? regs[rd_addr[AW-1:0]] : '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[8*g +: 8] = regs[g];
    end

    // R4: a mapped write request is visible in the register one cycle later
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> regs[$past(req.addr[AW-1:0])] == $past(req.data));

    // R8: a write to an unmapped address leaves every register unchanged
    assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (req.we && !wr_hit) |=> $stable(regs_o));
endmodule

// File: rtl/i2ct_engine.sv
`timescale 1ns/1ps
module i2ct_engine
    import i2ct_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_f,
    input  logic        sda_f,
    input  logic [2:0]  strap,
    input  byte_t       rd_data,
    output byte_t       rd_addr,
    output wr_req_t     wr,
    output logic        sda_pull
);
    logic   scl_q, sda_q;
    logic   start_ev, stop_ev, rise_ev, fall_ev;
    phase_e phase;
    logic [3:0] bitcnt;
    byte_t  shreg, ptr, tx;

    // bus conditions need SCL high both before and after the SDA step
    assign start_ev = scl_f && scl_q && sda_q && !sda_f;
    assign stop_ev  = scl_f && scl_q && !sda_q && sda_f;
    assign rise_ev  = scl_f && !scl_q;
    assign fall_ev  = !scl_f && scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            tx       <= '0;
            wr       <= '0;
            sda_pull <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wr.we <= 1'b0;
            if (start_ev) begin
                phase    <= PH_ID;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_ev) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (rise_ev) begin
                    if (bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else begin
                        bitcnt <= '0;
                        case (phase)
                            PH_ID:   phase <= id_match(shreg, strap) ?
                                              (shreg[0] ? PH_RD : PH_ADDR) : PH_SKIP;
                            PH_ADDR: begin
                                ptr   <= shreg;
                                phase <= PH_WR;
                            end
                            PH_WR: begin
                                wr  <= '{we: 1'b1, addr: ptr, data: shreg};
                                ptr <= ptr + 8'd1;
                            end
                            PH_RD: begin
                                if (sda_f) phase <= PH_SKIP;
                                else       ptr   <= ptr + 8'd1;
                            end
                            default: ;
                        endcase
                    end
                end else if (fall_ev) begin
                    if (bitcnt == 4'd8) begin
                        sda_pull <= (phase == PH_ADDR) || (phase == PH_WR) ||
                                    ((phase == PH_ID) && id_match(shreg, strap));
                    end else if (bitcnt == 4'd0) begin
                        if (phase == PH_RD) begin
                            tx       <= rd_data;
                            sda_pull <= !rd_data[7];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end else if (phase == PH_RD) begin
                        tx       <= {tx[6:0], 1'b0};
                        sda_pull <= !tx[6];
                    end
                end
            end
        end
    end

    assign rd_addr = ptr;

    // R11: at most one bus event per cycle; a simultaneous SCL rise wins over START/STOP
    assert_one_event_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_ev, stop_ev, rise_ev, fall_ev}));

    // R10: STOP always leaves SDA released
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_pull);

    // R4: a register write is issued only from the write phase on an SCL rise
    assert_strobe_in_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> ($past(phase) == PH_WR) && $past(rise_ev));

    // R6: the SDA drive changes only after an SCL fall or a bus condition
    assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> $past(fall_ev || start_ev || stop_ev));

    // R2: a rejected or finished transfer keeps SDA released
    assert_skip_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP || phase == PH_IDLE) |-> !sda_pull);
endmodule

// File: rtl/i2ct_target.sv
`timescale 1ns/1ps
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int    NUM_REGS    = 2,
    parameter int    FILT_CYCLES = 10,
    parameter byte_t RESET_VALUE = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [2:0]            strap_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, filt;
    wr_req_t          wr;
    byte_t            rd_addr, rd_data;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2ct_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[g]),
            .filt_o (filt[g])
        );
    end

    i2ct_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (filt[0]),
        .sda_f    (filt[1]),
        .strap    (strap_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr       (wr),
        .sda_pull (sda_pull_o)
    );

    i2ct_regbank #(.NUM_REGS(NUM_REGS), .RESET_VALUE(RESET_VALUE)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );
endmodule

// File: tb/i2ct_target_test.sv
`timescale 1ns/1ps
module i2ct_target_test;
    localparam int NREG = 2;
    localparam int FILT = 10;
    localparam int T    = 30;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] ID_W  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] ID_R  = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
    logic sda_pull;
    logic [NREG*8-1:0] regs;
    wire scl_line = m_scl ^ g_scl;
    wire sda_line = (m_sda ^ g_sda) & ~sda_pull;

    i2ct_target #(.NUM_REGS(NREG), .FILT_CYCLES(FILT), .RESET_VALUE(8'h40)) uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_line),
        .sda_i      (sda_line),
        .strap_i    (STRAP),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // scoreboard: driver pushes expected read bytes, monitor pops and compares
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rd_val;
    event       rd_ev;

    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected read byte", int'(rd_val), -1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_val == e, t, "read byte", int'(rd_val), int'(e));
            end
        end
    end

    // mode 0: normal, 1: short glitches on both lines, 2: SDA moves with SCL rise
    task automatic bit_w(input logic b, input int mode);
        if (mode == 2) begin
            tick(T);
            m_scl = 1'b1;
            m_sda = b;
            tick(T);
        end else if (mode == 1) begin
            m_sda = b;
            tick(5);
            g_scl = 1'b1;
            tick(FILT - 4);
            g_scl = 1'b0;
            tick(T - 5 - (FILT - 4));
            m_scl = 1'b1;
            tick(8);
            g_sda = 1'b1;
            tick(FILT - 4);
            g_sda = 1'b0;
            tick(T - 8 - (FILT - 4));
        end else begin
            m_sda = b;
            tick(T);
            m_scl = 1'b1;
            tick(T);
        end
        m_scl = 1'b0;
        tick(T);
    endtask

    task automatic bit_r(output logic v);
        m_sda = 1'b1;
        tick(T);
        m_scl = 1'b1;
        tick(T / 2);
        v = sda_line;
        tick(T - T / 2);
        m_scl = 1'b0;
        tick(T);
    endtask

    task automatic byte_w(input logic [7:0] val, input int mode, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(val[i], mode);
        bit_r(a);
        acked = !a;
    endtask

    task automatic byte_r(input logic [7:0] expv, input string tag, input bit host_ack);
        logic [7:0] v;
        logic b;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            v[i] = b;
        end
        rd_val = v;
        -> rd_ev;
        bit_w(!host_ack, 0);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(T);
        m_scl = 1'b1;
        tick(T);
        m_sda = 1'b0;
        tick(T);
        m_scl = 1'b0;
        tick(T);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(T);
        m_scl = 1'b1;
        tick(T);
        m_sda = 1'b1;
        tick(T);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic a;
        tick(6);
        rst = 1'b0;
        tick(4);

        // R9: reset state
        check(regs[7:0] == 8'h40, "R9", "reg0 after reset", int'(regs[7:0]), 'h40);
        check(regs[15:8] == 8'h40, "R9", "reg1 after reset", int'(regs[15:8]), 'h40);
        check(sda_pull == 1'b0, "R9", "SDA released after reset", int'(sda_pull), 0);

        // R2 R3 R4 R5: sequential write of two registers
        bus_start();
        byte_w(ID_W, 0, a);   check(a, "R2", "ack of matching id", int'(a), 1);
        byte_w(8'h00, 0, a);  check(a, "R3", "ack of address byte", int'(a), 1);
        byte_w(8'h12, 0, a);  check(a, "R4", "ack of data byte", int'(a), 1);
        check(regs[7:0] == 8'h12, "R4", "reg0 at ninth clock", int'(regs[7:0]), 'h12);
        byte_w(8'h34, 0, a);  check(a, "R5", "ack of second data byte", int'(a), 1);
        bus_stop();
        check(regs[15:8] == 8'h34, "R5", "reg1 by auto-increment", int'(regs[15:8]), 'h34);

        // R2: wrong strap bits, the rest of the transfer is ignored
        bus_start();
        byte_w({4'b1010, 3'b100, 1'b0}, 0, a);
        check(!a, "R2", "no ack for wrong id", int'(a), 0);
        byte_w(8'h00, 0, a);  check(!a, "R2", "no ack after rejected id", int'(a), 0);
        byte_w(8'h99, 0, a);
        bus_stop();
        check(regs == 16'h3412, "R2", "registers untouched after rejected id", int'(regs), 'h3412);

        // R10: bytes without START after STOP are ignored
        byte_w(ID_W, 0, a);   check(!a, "R10", "no ack while idle", int'(a), 0);
        byte_w(8'h01, 0, a);
        byte_w(8'hEE, 0, a);
        bus_stop();
        check(regs == 16'h3412, "R10", "registers untouched while idle", int'(regs), 'h3412);

        // R8: unmapped write is acknowledged and has no effect
        bus_start();
        byte_w(ID_W, 0, a);
        byte_w(8'h05, 0, a);  check(a, "R8", "ack of unmapped address", int'(a), 1);
        byte_w(8'h77, 0, a);  check(a, "R8", "ack of unmapped data", int'(a), 1);
        bus_stop();
        check(regs == 16'h3412, "R8", "unmapped write has no effect", int'(regs), 'h3412);

        // R6 R7 R8: combined read across the end of the map
        bus_start();
        byte_w(ID_W, 0, a);
        byte_w(8'h00, 0, a);
        bus_start();
        byte_w(ID_R, 0, a);   check(a, "R6", "ack of read id", int'(a), 1);
        byte_r(8'h12, "R6", 1'b1);
        byte_r(8'h34, "R7", 1'b1);
        byte_r(8'h00, "R8", 1'b0);
        bit_r(a);
        check(a == 1'b1, "R7", "SDA released after host NACK", int'(a), 1);
        bus_stop();

        // R1: glitches on SCL (low phase) and SDA (high phase) are rejected
        bus_start();
        byte_w(ID_W, 0, a);
        byte_w(8'h01, 0, a);
        byte_w(8'h5A, 1, a);  check(a, "R1", "ack with glitches", int'(a), 1);
        bus_stop();
        check(regs[15:8] == 8'h5A, "R1", "reg1 with glitches", int'(regs[15:8]), 'h5A);

        // R11: SDA changes on the same cycle as SCL rises
        bus_start();
        byte_w(ID_W, 0, a);
        byte_w(8'h00, 0, a);
        byte_w(8'hA5, 2, a);  check(a, "R11", "ack with simultaneous edges", int'(a), 1);
        bus_stop();
        check(regs[7:0] == 8'hA5, "R11", "reg0 with simultaneous edges", int'(regs[7:0]), 'hA5);

        // R6: single-byte read, MSB first on an asymmetric value
        bus_start();
        byte_w(ID_W, 0, a);
        byte_w(8'h00, 0, a);
        bus_start();
        byte_w(ID_R, 0, a);
        byte_r(8'hA5, "R6", 1'b0);
        bus_stop();
        tick(4);
        check(exp_q.size() == 0, "R6", "all expected reads seen", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule